// File: doc/BRIEF.md
# Hamming Sector Code Checker and Corrector

This block judges one 512-byte flash sector after a read. It takes two 3-byte Hamming codes: the code that was kept in the spare area when the sector was written, and the code that was computed again over the data just read. On a start strobe it compares the two codes and sorts the sector into one of five outcomes: clean, one data bit fixable, code damaged, blank (erased) sector, or beyond repair. For the fixable case it gives the byte index and the bit index of the flipped bit, along with a flip-enable flag. Logic outside the block uses these to toggle that bit in its sector buffer.

Each code is first rearranged into a 28-bit word. The two words are XORed to form a syndrome, and the number of ones in the syndrome decides the outcome. The result is latched on the clock edge that samples the start strobe. A one-cycle done pulse comes with it, and the result holds until the next start.

Top module: `sector_ecc_check`

## Requirements
- R1: Each 24-bit code input holds byte0 in bits 7:0, byte1 in bits 15:8 and byte2 in bits 23:16. It is rearranged into a 28-bit word with byte0 at bits 7:0, the low nibble of byte2 at bits 11:8, zeros at bits 15:12, byte1 at bits 23:16 and the high nibble of byte2 at bits 27:24. The syndrome is the XOR of the stored word and the computed word.
- R2: When the syndrome is zero, status_o is 0 (clean).
- R3: When the syndrome has exactly 12 ones, status_o is 1 (fixable). bit_idx_o equals syndrome bits 18:16 and byte_idx_o equals syndrome bits 27:19.
- R4: When the syndrome has exactly one set bit, status_o is 2 (stored code damaged).
- R5: For any other nonzero syndrome, status_o is 3 (erased sector, treated as good) when the stored word equals 28'h0FFF0FFF and the computed word is zero. On the input ports this is stored code 24'hFFFFFF with computed code 24'h000000.
- R6: Every remaining nonzero syndrome gives status_o 4 (two or more bits wrong).
- R7: flip_en_o is 1 only when status_o is 1. byte_idx_o and bit_idx_o are zero for every other status.
- R8: All results load on the rising clock edge that samples start_i high. done_o is high for exactly the cycle after each such edge.
- R9: While start_i is low, status_o, flip_en_o, byte_idx_o and bit_idx_o keep their values, whatever the code inputs do.
- R10: While reset is active, and after it until the first start, done_o, flip_en_o, status_o, byte_idx_o and bit_idx_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Evaluate the two codes on this edge |
| stored_code_i | input | 24 | Code read from the spare area |
| calc_code_i | input | 24 | Code recomputed over the sector data |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| status_o | output | 3 | 0 clean, 1 fixable, 2 code damaged, 3 erased, 4 uncorrectable |
| flip_en_o | output | 1 | Toggle the indicated data bit |
| byte_idx_o | output | 9 | Byte index of the flipped bit |
| bit_idx_o | output | 3 | Bit index inside that byte |

## Verification
The bench builds the block with its default sector size of 512 bytes. This gives the 9-bit byte index that the syndrome packing requires, so the extreme locations byte 0 bit 0 and byte 511 bit 7 can both be driven directly. With these values, vectors whose syndrome weight is 1, 2, 12, 23 and 24 can also be formed. This covers both the erased pattern and its mirror image, which must be rejected, and a fixable error hidden under a nonzero computed code.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [2:0] {
    HST_CLEAN   = 3'd0,
    HST_FIXED   = 3'd1,
    HST_BADCODE = 3'd2,
    HST_ERASED  = 3'd3,
    HST_MULTI   = 3'd4
  } hecc_status_e;

  localparam int CODE_W       = 24;
  localparam int PACK_W       = 28;
  localparam int BIT_IDX_W    = 3;
  localparam int IDX_LSB      = 16;
  localparam int FIX_WEIGHT   = 12;
  localparam int BAD_WEIGHT   = 1;
  localparam logic [PACK_W-1:0] ERASED_WORD = 28'h0FFF0FFF;

endpackage

// File: rtl/hecc_rst_sync.sv
module hecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn_o = sync_q[STAGES-1];
endmodule

// File: rtl/hecc_repack.sv
module hecc_repack
  import hecc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [PACK_W-1:0] word_o
);
  // high nibble of byte2 on top, byte1, four zero bits, low nibble of byte2, byte0
  assign word_o = {code_i[23:20], code_i[15:8], 4'b0000, code_i[19:16], code_i[7:0]};
endmodule

// File: rtl/hecc_popcount.sv
module hecc_popcount #(
  parameter int W     = 28,
  parameter int OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [OUT_W-1:0] ones_o
);
  always_comb begin
    ones_o = '0;
    for (int i = 0; i < W; i++) begin
      ones_o = ones_o + OUT_W'(vec_i[i]);
    end
  end
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic [PACK_W-1:0]    stored_w_i,
  input  logic [PACK_W-1:0]    calc_w_i,
  output hecc_status_e         status_o,
  output logic                 flip_o,
  output logic [BYTE_W-1:0]    byte_o,
  output logic [BIT_IDX_W-1:0] bit_o
);
  localparam int CNT_W = $clog2(PACK_W + 1);

  logic [PACK_W-1:0] syndrome;
  logic [CNT_W-1:0]  weight;
  logic              erased_hit;

  assign syndrome   = stored_w_i ^ calc_w_i;
  assign erased_hit = (stored_w_i == ERASED_WORD) && (calc_w_i == '0);

  hecc_popcount #(.W(PACK_W), .OUT_W(CNT_W)) u_pop (
    .vec_i  (syndrome),
    .ones_o (weight)
  );

  always_comb begin
    status_o = HST_CLEAN;
    flip_o   = 1'b0;
    byte_o   = '0;
    bit_o    = '0;
    if (syndrome == '0) begin
      status_o = HST_CLEAN;
    end else if (weight == CNT_W'(FIX_WEIGHT)) begin
      status_o = HST_FIXED;
      flip_o   = 1'b1;
      bit_o    = syndrome[IDX_LSB +: BIT_IDX_W];
      byte_o   = syndrome[IDX_LSB + BIT_IDX_W +: BYTE_W];
    end else if (weight == CNT_W'(BAD_WEIGHT)) begin
      status_o = HST_BADCODE;
    end else if (erased_hit) begin
      status_o = HST_ERASED;
    end else begin
      status_o = HST_MULTI;
    end
  end
endmodule

// File: rtl/sector_ecc_check.sv
module sector_ecc_check
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [23:0] stored_code_i,
  input  logic [23:0] calc_code_i,
  output logic        done_o,
  output logic [2:0]  status_o,
  output logic        flip_en_o,
  output logic [8:0]  byte_idx_o,
  output logic [2:0]  bit_idx_o
);
  localparam int BYTE_W = $clog2(SECTOR_BYTES);

  logic rst_sn;
  logic [PACK_W-1:0] words [2];
  logic [CODE_W-1:0] codes [2];

  hecc_status_e        cls_status;
  logic                cls_flip;
  logic [BYTE_W-1:0]   cls_byte;
  logic [BIT_IDX_W-1:0] cls_bit;

  hecc_status_e        status_q, status_d;
  logic                flip_q, flip_d;
  logic [BYTE_W-1:0]   byte_q, byte_d;
  logic [BIT_IDX_W-1:0] bit_q, bit_d;
  logic                done_q, done_d;

  hecc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_sn_o (rst_sn)
  );

  assign codes[0] = stored_code_i;
  assign codes[1] = calc_code_i;

  for (genvar g = 0; g < 2; g++) begin : g_pack
    hecc_repack u_pack (
      .code_i (codes[g]),
      .word_o (words[g])
    );
  end

  hecc_classify #(.BYTE_W(BYTE_W)) u_cls (
    .stored_w_i (words[0]),
    .calc_w_i   (words[1]),
    .status_o   (cls_status),
    .flip_o     (cls_flip),
    .byte_o     (cls_byte),
    .bit_o      (cls_bit)
  );

  always_comb begin
    status_d = status_q;
    flip_d   = flip_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    done_d   = 1'b0;
    if (start_i) begin
      status_d = cls_status;
      flip_d   = cls_flip;
      byte_d   = cls_byte;
      bit_d    = cls_bit;
      done_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      status_q <= HST_CLEAN;
      flip_q   <= 1'b0;
      byte_q   <= '0;
      bit_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      flip_q   <= flip_d;
      byte_q   <= byte_d;
      bit_q    <= bit_d;
      done_q   <= done_d;
    end
  end

  assign done_o     = done_q;
  assign status_o   = status_q;
  assign flip_en_o  = flip_q;
  assign byte_idx_o = 9'(byte_q);
  assign bit_idx_o  = bit_q;
endmodule

// File: rtl/sector_ecc_check_chk.sv
module sector_ecc_check_chk (
  input logic        clk,
  input logic        rst_sn,
  input logic        start_i,
  input logic [23:0] stored_code_i,
  input logic [23:0] calc_code_i,
  input logic        done_o,
  input logic [2:0]  status_o,
  input logic        flip_en_o,
  input logic [8:0]  byte_idx_o,
  input logic [2:0]  bit_idx_o
);
  a_r2_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_i && stored_code_i == calc_code_i) |=> (status_o == 3'd0 && !flip_en_o));

  a_r5_erased_page: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_i && stored_code_i == 24'hFFFFFF && calc_code_i == 24'h000000) |=> (status_o == 3'd3));

  a_r6_status_range: assert property (@(posedge clk) disable iff (!rst_sn)
    status_o <= 3'd4);

  a_r7_flip_only_fixed: assert property (@(posedge clk) disable iff (!rst_sn)
    flip_en_o |-> (status_o == 3'd1));

  a_r7_idx_zero_else: assert property (@(posedge clk) disable iff (!rst_sn)
    (status_o != 3'd1) |-> (byte_idx_o == 9'd0 && bit_idx_o == 3'd0));

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_sn)
    start_i |=> done_o);

  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_sn)
    !start_i |=> !done_o);

  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_sn)
    !start_i |=> ($stable(status_o) && $stable(flip_en_o) && $stable(byte_idx_o) && $stable(bit_idx_o)));
endmodule

bind sector_ecc_check sector_ecc_check_chk u_chk (
  .clk           (clk),
  .rst_sn        (rst_sn),
  .start_i       (start_i),
  .stored_code_i (stored_code_i),
  .calc_code_i   (calc_code_i),
  .done_o        (done_o),
  .status_o      (status_o),
  .flip_en_o     (flip_en_o),
  .byte_idx_o    (byte_idx_o),
  .bit_idx_o     (bit_idx_o)
);

// File: tb/sector_ecc_check_bench.sv
module sector_ecc_check_bench;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] stored_code_i;
  logic [23:0] calc_code_i;
  logic        done_o;
  logic [2:0]  status_o;
  logic        flip_en_o;
  logic [8:0]  byte_idx_o;
  logic [2:0]  bit_idx_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  sector_ecc_check u_sector_ecc_check (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stored_code_i (stored_code_i),
    .calc_code_i   (calc_code_i),
    .done_o        (done_o),
    .status_o      (status_o),
    .flip_en_o     (flip_en_o),
    .byte_idx_o    (byte_idx_o),
    .bit_idx_o     (bit_idx_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam int NV = 12;
  // stored code, computed code, status, byte, bit, requirement tag
  localparam logic [23:0] T_ST [NV] = '{24'h123456, 24'h0F2BD4, 24'hF0FF00, 24'h0F00FF,
                                        24'hAAE8E8, 24'h000FFF, 24'h000001, 24'h100000,
                                        24'hFFFFFF, 24'hFFFFFF, 24'h000003, 24'h000000};
  localparam logic [23:0] T_CA [NV] = '{24'h123456, 24'h000000, 24'h000000, 24'h000000,
                                        24'hA5C33C, 24'h000000, 24'h000000, 24'h000000,
                                        24'h000000, 24'h000001, 24'h000000, 24'hFFFFFF};
  localparam logic [2:0]  T_STAT [NV] = '{3'd0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1,
                                          3'd2, 3'd2, 3'd3, 3'd4, 3'd4, 3'd4};
  localparam logic [8:0]  T_BYTE [NV] = '{9'd0, 9'd5, 9'd511, 9'd0, 9'd5, 9'd1,
                                          9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0};
  localparam logic [2:0]  T_BIT  [NV] = '{3'd0, 3'd3, 3'd7, 3'd0, 3'd3, 3'd7,
                                          3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0};
  localparam logic [15:0] T_REQ  [NV] = '{"R2", "R3", "R1", "R1", "R3", "R3",
                                          "R4", "R4", "R5", "R6", "R6", "R6"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // drive one start at negedge, sample at the following negedge
  task automatic fire(input logic [23:0] st, input logic [23:0] ca);
    @(negedge clk);
    stored_code_i = st;
    calc_code_i   = ca;
    start_i       = 1'b1;
    @(negedge clk);
    start_i       = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    stored_code_i = '0;
    calc_code_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(done_o == 1'b0,     "R10 done",   done_o, 0);
    check(status_o == 3'd0,   "R10 status", status_o, 0);
    check(flip_en_o == 1'b0,  "R10 flip",   flip_en_o, 0);
    check(byte_idx_o == 9'd0 && bit_idx_o == 3'd0, "R10 idx", byte_idx_o, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("%s vec%0d", T_REQ[i], i);
      fire(T_ST[i], T_CA[i]);
      check(done_o == 1'b1, {tag, " R8 done"}, done_o, 1);
      check(status_o == T_STAT[i], {tag, " status"}, status_o, T_STAT[i]);
      check(flip_en_o == (T_STAT[i] == 3'd1), {tag, " R7 flip"}, flip_en_o, int'(T_STAT[i] == 3'd1));
      check(byte_idx_o == T_BYTE[i], {tag, " byte"}, byte_idx_o, T_BYTE[i]);
      check(bit_idx_o == T_BIT[i], {tag, " bit"}, bit_idx_o, T_BIT[i]);
      @(negedge clk);
      check(done_o == 1'b0, {tag, " R8 pulse end"}, done_o, 0);
    end

    // R9: inputs change without start, result must hold
    fire(24'h0F2BD4, 24'h000000);
    @(negedge clk);
    stored_code_i = 24'h000003;
    calc_code_i   = 24'h000000;
    repeat (3) @(negedge clk);
    check(status_o == 3'd1,  "R9 hold status", status_o, 1);
    check(byte_idx_o == 9'd5 && bit_idx_o == 3'd3, "R9 hold idx", byte_idx_o, 5);
    check(flip_en_o == 1'b1, "R9 hold flip", flip_en_o, 1);
    check(done_o == 1'b0,    "R9 no done", done_o, 0);

    // R8: back-to-back starts, each gives done and the newest result
    @(negedge clk);
    stored_code_i = 24'hF0FF00; calc_code_i = 24'h000000; start_i = 1'b1;
    @(negedge clk);
    check(done_o == 1'b1 && byte_idx_o == 9'd511, "R8 first of pair", byte_idx_o, 511);
    stored_code_i = 24'h000001;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b1, "R8 second done", done_o, 1);
    check(status_o == 3'd2 && flip_en_o == 1'b0, "R8 second status", status_o, 2);
    @(negedge clk);
    check(done_o == 1'b0, "R8 pair end", done_o, 0);

    // R10: reset after a fixable result clears outputs
    fire(24'h0F2BD4, 24'h000000);
    rst_n = 1'b0;
    @(negedge clk);
    check(status_o == 3'd0 && flip_en_o == 1'b0 && byte_idx_o == 9'd0, "R10 mid reset", status_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0 && status_o == 3'd0, "R10 after release", status_o, 0);

    summary();
  end
endmodule